// File: doc/BRIEF.md
# Biphase Serial Word Receiver

This block turns a biphase-coded (Manchester II) serial line into NRZ bits. The system clock runs at twelve times the bit rate. The line reaches the block in one of three ways: as a bipolar pair, as a single unipolar wire, or as an already-synchronised data input that skips the metastability stages. The block resynchronises its half-cell sampling point on every line transition. While idle it hunts for a three-bit-time sync character and records whether that character was high-first (command) or low-first (data).

After the sync character it decodes the word bit by bit. Each bit appears on a serial data output together with a one-cycle shift strobe. A take-data window opens once two good bits have arrived. A one-cycle valid-word pulse follows the final bit, but only when odd parity holds and no bit broke the biphase rule.

A free-running copy of the take-data window is always produced. It counts whole word frames on its own and realigns to every detected sync character, so that during a word it matches take-data exactly. The sampling point can also come from an external strobe in place of the internal half-cell timer.

Top module: `mrx_top`

The character identifier is a four-state machine:

- HUNT: waiting for a sync character. It moves to FIRST on a sync match.
- FIRST: sampling the first half of a bit. It moves to SECOND on the next sample.
- SECOND: sampling the second half. It returns to FIRST for the next bit. It moves to FINISH after the last bit. On an early coding error it aborts back to HUNT.
- FINISH: one cycle in which the verdict is published. It then returns to HUNT.

## Requirements
- R1: The line level is `pos_in | (uni_in & neg_in)`. In bipolar use, `uni_in` is held low and the level follows `pos_in`, high meaning the positive bus state. In unipolar use, `pos_in` is 0 and `neg_in` is 1, and the level follows `uni_in`.
- R2: With `sdat_sel` high, `sdat_in` bypasses the synchroniser and is taken as the line level through a single register. With `sdat_sel` low, the bipolar/unipolar level passes SYNC_STAGES synchroniser stages and then that register.
- R3: With `sclk_sel` low, the line is sampled once every OSR/2 clocks, and every transition realigns the sampling point. With `sclk_sel` high, the line is sampled only in cycles where `ext_tick` is high, so a word sent with no `ext_tick` produces no output activity.
- R4: In HUNT, seven consecutive half-cell samples 0111000 (oldest first) form a command sync and set `word_cmd`=1. Samples 1000111 form a data sync and set `word_cmd`=0.
- R5: Each bit is two half-cells, and its value is the first half (high-then-low = 1). Bits leave on `sdo` in arrival order: NDATA data bits, then one parity bit. Each bit comes with a one-cycle `shift_clk` pulse in which `sdo` is valid.
- R6: `take_data` rises in the cycle of the second bit's `shift_clk` pulse. It stays high through the pulses of bits 2 to NDATA, and it is low in the cycle of the final (parity) bit's pulse.
- R7: A bit whose two halves are equal is a coding error. If bit 0 or bit 1 has a coding error, the word is abandoned: that bit gives no pulse, no later pulse follows, and neither `take_data` nor `valid_word` rises.
- R8: `valid_word` is a one-cycle pulse in the cycle after the final `shift_clk` pulse. It appears only when no bit had a coding error and the XOR of all NDATA+1 bits is 1. A coding error in a later bit still shifts that bit out, as its first-half value.
- R9: `word_cmd` changes only when a sync character is detected, and keeps its value otherwise.
- R10: `take_free` keeps running without any word, with a period of 2*(NDATA+1)+6 samples. Whenever `take_data` is high, `take_free` is high, and both fall in the same cycle.
- R11: While `rst` is high, every output is low and the identifier returns to HUNT, including in the middle of a word.
- R12: A word whose parity bit makes the XOR of all NDATA+1 bits 0 gets all of its shift pulses but no `valid_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at OSR times the bit rate |
| rst | input | 1 | Synchronous master reset, active high |
| pos_in | input | 1 | High while the bus is positive |
| neg_in | input | 1 | High while the bus is negative; held high in unipolar use |
| uni_in | input | 1 | Unipolar line, held low when unused |
| sdat_sel | input | 1 | Selects the pre-synchronised data input |
| sdat_in | input | 1 | Pre-synchronised biphase data |
| sclk_sel | input | 1 | Selects `ext_tick` as the sampling strobe |
| ext_tick | input | 1 | External half-cell sampling strobe |
| sdo | output | 1 | Decoded NRZ bit |
| shift_clk | output | 1 | One-cycle strobe per decoded bit |
| take_data | output | 1 | Data-receive window |
| take_free | output | 1 | Free-running copy of the receive window |
| valid_word | output | 1 | Good-word pulse |
| word_cmd | output | 1 | 1 after a command sync, 0 after a data sync |

## Verification
The bench builds the block with OSR=12, NDATA=16 and SYNC_STAGES=2. These values give a six-clock half-cell and a 17-bit word, so every path can be reached within a few hundred cycles per word. That covers the bipolar, unipolar and pre-synchronised paths, both sync polarities, and aborts on the first and second bit. It also covers a late coding error, a parity failure, sampling gated off and on by the external strobe, and a reset in the middle of a word. With the 40-sample frame, the free-running window wraps several times during one idle stretch.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FIRST,
        ST_SECOND,
        ST_FINISH
    } mrx_state_e;

    // seven-sample sync windows, oldest sample on the left
    localparam logic [6:0] SYNC_CMD = 7'b0111000;
    localparam logic [6:0] SYNC_DAT = 7'b1000111;

endpackage

// File: rtl/mrx_front.sv
module mrx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    input  logic uni_i,
    input  logic sdat_sel_i,
    input  logic sdat_i,
    output logic lvl_o,
    output logic edge_o
);

    logic                   raw_lvl;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_q;
    logic                   lvl_d;

    // the unipolar wire only counts while the negative input is held high
    assign raw_lvl = pos_i | (uni_i & neg_i);

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw_lvl;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_lvl};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            lvl_q <= sdat_sel_i ? sdat_i : sync_q[SYNC_STAGES-1];
            lvl_d <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign edge_o = lvl_q ^ lvl_d;

    a_r1_bipolar_level: assert property (@(posedge clk) disable iff (rst)
        (!rst && pos_i) |=> sync_q[0]);
    a_r1_unipolar_level: assert property (@(posedge clk) disable iff (rst)
        (!rst && !pos_i && neg_i) |=> (sync_q[0] == $past(uni_i)));
    a_r2_sync_bypass: assert property (@(posedge clk) disable iff (rst)
        (!rst && sdat_sel_i) |=> (lvl_o == $past(sdat_i)));

endmodule

// File: rtl/mrx_timing.sv
module mrx_timing #(
    parameter int OSR = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic sclk_sel_i,
    input  logic ext_tick_i,
    output logic tick_o
);

    localparam int HALF      = OSR / 2;
    localparam int PW        = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int SAMPLE_AT = (HALF / 2 > 0) ? HALF / 2 - 1 : 0;

    logic [PW-1:0] ph_q;
    logic          tick_int;

    always_ff @(posedge clk) begin
        if (rst)                        ph_q <= '0;
        else if (edge_i)                ph_q <= '0;
        else if (ph_q == PW'(HALF - 1)) ph_q <= '0;
        else                            ph_q <= ph_q + 1'b1;
    end

    assign tick_int = (ph_q == PW'(SAMPLE_AT)) && !edge_i;
    assign tick_o   = sclk_sel_i ? ext_tick_i : tick_int;

    a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
        ph_q <= PW'(HALF - 1));
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (!sclk_sel_i && !$past(sclk_sel_i) && $past(tick_o)) |-> !tick_o);
    a_r3_ext_gate: assert property (@(posedge clk) disable iff (rst)
        (sclk_sel_i && !ext_tick_i) |-> !tick_o);

endmodule

// File: rtl/mrx_charid.sv
module mrx_charid
    import mrx_pkg::*;
#(
    parameter int NBITS = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic lvl_i,
    output logic sdo_o,
    output logic shift_o,
    output logic take_o,
    output logic valid_o,
    output logic cmd_o,
    output logic sync_hit_o
);

    localparam int CW = $clog2(NBITS + 1);

    mrx_state_e     state_q, state_n;
    logic [5:0]     sh_q;
    logic [6:0]     win;
    logic           first_q, first_n;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic           par_q, par_n;
    logic           err_q, err_n;
    logic           bad;
    logic           hit;
    logic           sdo_n, shift_n, take_n, valid_n, cmd_n;

    // next-state and next-output logic
    always_comb begin
        win     = {sh_q, lvl_i};
        state_n = state_q;
        first_n = first_q;
        cnt_n   = cnt_q;
        par_n   = par_q;
        err_n   = err_q;
        sdo_n   = sdo_o;
        take_n  = take_o;
        cmd_n   = cmd_o;
        shift_n = 1'b0;
        valid_n = 1'b0;
        hit     = 1'b0;
        bad     = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (tick_i && (win == SYNC_CMD || win == SYNC_DAT)) begin
                    hit     = 1'b1;
                    cmd_n   = (win == SYNC_CMD);
                    cnt_n   = '0;
                    par_n   = 1'b0;
                    err_n   = 1'b0;
                    state_n = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (tick_i) begin
                    first_n = lvl_i;
                    state_n = ST_SECOND;
                end
            end
            ST_SECOND: begin
                if (tick_i) begin
                    bad = (first_q == lvl_i);
                    if (bad && cnt_q < CW'(2)) begin
                        take_n  = 1'b0;
                        state_n = ST_HUNT;
                    end else begin
                        sdo_n   = first_q;
                        shift_n = 1'b1;
                        par_n   = par_q ^ first_q;
                        err_n   = err_q | bad;
                        cnt_n   = cnt_q + 1'b1;
                        if (cnt_q == CW'(1)) take_n = 1'b1;
                        if (cnt_q == CW'(NBITS - 1)) begin
                            take_n  = 1'b0;
                            state_n = ST_FINISH;
                        end else begin
                            state_n = ST_FIRST;
                        end
                    end
                end
            end
            ST_FINISH: begin
                valid_n = par_q && !err_q;
                state_n = ST_HUNT;
            end
            default: state_n = ST_HUNT;
        endcase
    end

    // state register and word accumulators
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            sh_q    <= '0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            par_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (tick_i) sh_q <= win[5:0];
            first_q <= first_n;
            cnt_q   <= cnt_n;
            par_q   <= par_n;
            err_q   <= err_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_o   <= 1'b0;
            shift_o <= 1'b0;
            take_o  <= 1'b0;
            valid_o <= 1'b0;
            cmd_o   <= 1'b0;
        end else begin
            sdo_o   <= sdo_n;
            shift_o <= shift_n;
            take_o  <= take_n;
            valid_o <= valid_n;
            cmd_o   <= cmd_n;
        end
    end

    assign sync_hit_o = hit;

    a_r5_shift_on_tick: assert property (@(posedge clk) disable iff (rst)
        shift_o |-> $past(tick_i));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(NBITS));
    a_r6_take_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(take_o) |-> shift_o);
    a_r6_take_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(take_o) |-> shift_o);
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    a_r8_valid_after_shift: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(shift_o) && !take_o));
    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(hit) |-> $stable(cmd_o));

endmodule

// File: rtl/mrx_strobe.sv
module mrx_strobe #(
    parameter int NBITS = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sync_hit_i,
    output logic free_o
);

    localparam int FRAME  = 2 * NBITS + 6;
    localparam int FW     = $clog2(FRAME);
    localparam int ON_AT  = 4;
    localparam int OFF_AT = 2 * NBITS;

    logic [FW-1:0] fc_q, fc_n;

    always_comb begin
        if (sync_hit_i)                  fc_n = '0;
        else if (fc_q == FW'(FRAME - 1)) fc_n = '0;
        else                             fc_n = fc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q   <= '0;
            free_o <= 1'b0;
        end else if (tick_i) begin
            fc_q   <= fc_n;
            free_o <= (fc_n >= FW'(ON_AT)) && (fc_n < FW'(OFF_AT));
        end
    end

    a_r10_frame_bound: assert property (@(posedge clk) disable iff (rst)
        fc_q <= FW'(FRAME - 1));
    a_r10_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_i) |-> $stable(free_o));

endmodule

// File: rtl/mrx_top.sv
module mrx_top #(
    parameter int OSR         = 12,
    parameter int NDATA       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_in,
    input  logic neg_in,
    input  logic uni_in,
    input  logic sdat_sel,
    input  logic sdat_in,
    input  logic sclk_sel,
    input  logic ext_tick,
    output logic sdo,
    output logic shift_clk,
    output logic take_data,
    output logic take_free,
    output logic valid_word,
    output logic word_cmd
);

    localparam int NBITS = NDATA + 1;

    logic lvl;
    logic edge_seen;
    logic tick;
    logic sync_hit;

    mrx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .pos_i      (pos_in),
        .neg_i      (neg_in),
        .uni_i      (uni_in),
        .sdat_sel_i (sdat_sel),
        .sdat_i     (sdat_in),
        .lvl_o      (lvl),
        .edge_o     (edge_seen)
    );

    mrx_timing #(.OSR(OSR)) u_timing (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (edge_seen),
        .sclk_sel_i (sclk_sel),
        .ext_tick_i (ext_tick),
        .tick_o     (tick)
    );

    mrx_charid #(.NBITS(NBITS)) u_charid (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .lvl_i      (lvl),
        .sdo_o      (sdo),
        .shift_o    (shift_clk),
        .take_o     (take_data),
        .valid_o    (valid_word),
        .cmd_o      (word_cmd),
        .sync_hit_o (sync_hit)
    );

    mrx_strobe #(.NBITS(NBITS)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .sync_hit_i (sync_hit),
        .free_o     (take_free)
    );

    a_r10_take_in_free: assert property (@(posedge clk) disable iff (rst)
        take_data |-> take_free);
    a_r10_fall_together: assert property (@(posedge clk) disable iff (rst)
        $fell(take_data) |-> !take_free);
    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(shift_clk || take_data || valid_word || take_free));

endmodule

// File: tb/mrx_top_bench.sv
module mrx_top_bench;

    localparam int OSR   = 12;
    localparam int NDATA = 16;
    localparam int NB    = NDATA + 1;
    localparam int HALF  = OSR / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos_in = 1'b0, neg_in = 1'b1, uni_in = 1'b0;
    logic sdat_sel = 1'b0, sdat_in = 1'b0;
    logic sclk_sel = 1'b0, ext_tick = 1'b0;
    logic sdo, shift_clk, take_data, take_free, valid_word, word_cmd;

    mrx_top #(.OSR(OSR), .NDATA(NDATA), .SYNC_STAGES(2)) u_mrx_top (
        .clk(clk), .rst(rst), .pos_in(pos_in), .neg_in(neg_in), .uni_in(uni_in),
        .sdat_sel(sdat_sel), .sdat_in(sdat_in), .sclk_sel(sclk_sel), .ext_tick(ext_tick),
        .sdo(sdo), .shift_clk(shift_clk), .take_data(take_data), .take_free(take_free),
        .valid_word(valid_word), .word_cmd(word_cmd)
    );

    always #5 clk = ~clk;

    int   checks = 0, fails = 0;
    bit   done = 0;
    int   mode = 0;       // 0 bipolar, 1 unipolar, 2 pre-synchronised
    bit   use_ext = 0, ext_gate = 1;
    logic cur_lvl = 1'b0;
    logic exp_q[$];
    int   k = 0, shift_seen = 0, valid_seen = 0, free_rises = 0;
    logic last_shift = 1'b0, last_free = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic drive_level(input logic l);
        cur_lvl = l;
        case (mode)
            0: begin pos_in = l; neg_in = ~l; uni_in = 1'b0; end
            1: begin pos_in = 1'b0; neg_in = 1'b1; uni_in = l; end
            default: sdat_in = l;
        endcase
    endtask

    task automatic half(input logic l);
        for (int i = 0; i < HALF; i++) begin
            @(posedge clk); #1;
            if (i == 0) drive_level(l);
            ext_tick = use_ext && ext_gate && (i == 4);
        end
    endtask

    // behavioural reference: expected bit queue, pulse counts and windows
    always @(negedge clk) begin
        if (!rst) begin
            if (shift_clk) begin
                k++;
                shift_seen++;
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected shift", 1, 0);
                else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(sdo == e, "R5 bit value", sdo, e);
                end
                chk(take_data == (k >= 2 && k <= NB - 1), "R6 take window", take_data, (k >= 2 && k <= NB - 1));
            end
            if (valid_word) begin
                valid_seen++;
                chk(last_shift && k == NB, "R8 valid timing", k, NB);
            end
            if (take_data) chk(take_free == 1'b1, "R10 free during take", take_free, 1);
            if (take_free && !last_free) free_rises++;
            last_shift = shift_clk;
            last_free  = take_free;
        end
    end

    task automatic send_word(input logic cmd, input logic [NDATA-1:0] d, input int errbit,
                             input bit badpar, input bit no_ticks, input string tag);
        logic [NB-1:0] bits;
        logic prev_cmd, b;
        int   exp_n;
        bit   exp_v;
        bits     = {d, ~(^d) ^ badpar};
        prev_cmd = word_cmd;
        exp_q.delete();
        k = 0; shift_seen = 0; valid_seen = 0;
        if (no_ticks) exp_n = 0;
        else if (errbit == 0 || errbit == 1) exp_n = errbit;
        else exp_n = NB;
        for (int i = 0; i < exp_n; i++) exp_q.push_back(bits[NB-1-i]);
        exp_v = !no_ticks && (errbit < 0) && !badpar;
        for (int i = 0; i < 4; i++) half(!cmd);
        for (int i = 0; i < 3; i++) half(cmd);
        for (int i = 0; i < 3; i++) half(!cmd);
        for (int i = 0; i < NB; i++) begin
            b = bits[NB-1-i];
            half(b);
            half((i == errbit) ? b : !b);
        end
        for (int i = 0; i < 6; i++) half(cur_lvl);
        chk(shift_seen == exp_n, {tag, " shift count"}, shift_seen, exp_n);
        chk(valid_seen == int'(exp_v), {tag, " valid pulse"}, valid_seen, exp_v);
        chk(word_cmd == (no_ticks ? prev_cmd : cmd), {tag, " R4 R9 sync type"}, word_cmd, no_ticks ? prev_cmd : cmd);
        chk(exp_q.size() == 0, {tag, " R5 missing bits"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog all actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(!(sdo | shift_clk | take_data | take_free | valid_word | word_cmd), "R11 reset outputs", 1, 0);
        rst = 1'b0;
        // R10: free-running window with an idle line
        for (int i = 0; i < 100; i++) half(1'b0);
        chk(free_rises >= 2, "R10 free runs idle", free_rises, 2);
        send_word(1'b1, 16'hA5C3, -1, 1'b0, 1'b0, "R8 cmd word");
        send_word(1'b0, 16'h0001, -1, 1'b0, 1'b0, "R4 data word");
        send_word(1'b1, 16'h7E18, -1, 1'b1, 1'b0, "R12 bad parity");
        send_word(1'b0, 16'h3C5A, 9, 1'b0, 1'b0, "R8 late coding error");
        send_word(1'b1, 16'h1234, 0, 1'b0, 1'b0, "R7 abort bit0");
        send_word(1'b1, 16'h1234, 1, 1'b0, 1'b0, "R7 abort bit1");
        send_word(1'b1, 16'hBEEF, -1, 1'b0, 1'b0, "R5 after abort");
        mode = 1;
        send_word(1'b0, 16'hC001, -1, 1'b0, 1'b0, "R1 unipolar");
        mode = 2; sdat_sel = 1'b1;
        send_word(1'b1, 16'h5555, -1, 1'b0, 1'b0, "R2 presync path");
        mode = 0; sdat_sel = 1'b0;
        use_ext = 1; sclk_sel = 1'b1; ext_gate = 0;
        send_word(1'b0, 16'h9999, -1, 1'b0, 1'b1, "R3 no ext tick");
        ext_gate = 1;
        send_word(1'b0, 16'h8421, -1, 1'b0, 1'b0, "R3 ext tick");
        use_ext = 0; sclk_sel = 1'b0; ext_tick = 1'b0;
        // R11: reset in the middle of a word
        exp_q.delete(); k = 0;
        exp_q.push_back(1'b1); exp_q.push_back(1'b1);
        for (int i = 0; i < 4; i++) half(1'b0);
        for (int i = 0; i < 3; i++) half(1'b1);
        for (int i = 0; i < 3; i++) half(1'b0);
        for (int i = 0; i < 3; i++) begin half(1'b1); half(1'b0); end
        chk(take_data == 1'b1, "R6 take open mid word", take_data, 1);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!(shift_clk | take_data | take_free | valid_word | word_cmd), "R11 mid-word reset", take_data, 0);
        exp_q.delete();
        @(posedge clk); #1;
        rst = 1'b0;
        send_word(1'b1, 16'h0F0F, -1, 1'b0, 1'b0, "R11 word after reset");
        done = 1;
        summary();
        $finish;
    end

endmodule